// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache with Translation-Overlapped Lookup

This block is a two-way set-associative data cache that sits between a load/store unit and a next-level memory. It picks the set and the word from the low, untranslated bits of the virtual address. Those bits never change under translation, so the set can be read in the same cycle in which the translation buffer produces the physical page tag. The two stored tags are then compared against that physical tag. A hit needs a matching valid way and also a translation hit.

Each line holds four 32-bit words, and the default build has 64 sets. Stores are kept in the cache, and a per-line modified flag marks lines that must be copied out. A modified line goes to the next level only when it is chosen as a victim. On a miss the block raises `busy`. If the victim is modified, it copies the victim out first. It then fetches the whole new line, installs it, and completes the access that was waiting. A single bit per set remembers which way was used less recently.

Top module: `vipt_cache`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `rsp_valid` and `mem_req` are low. All lines start invalid, so the first access to any set is a miss.
- R2: The set is taken from `req_vaddr[9:4]` and the word within the line from `req_vaddr[3:2]`. Bits 31:10 and 1:0 of `req_vaddr` have no effect, so two virtual addresses that differ only in bits 31:12 reach the same line.
- R3: An access hits when a valid way holds a tag equal to `req_ptag` and `req_tlb_hit` is 1. One cycle after the strobe, `rsp_valid` and `rsp_hit` are 1 and `rsp_rdata` holds the addressed word, with no memory traffic and no `busy`. A tag that differs from the stored one is a miss.
- R4: An access strobed with `req_tlb_hit` at 0 completes one cycle later with `rsp_valid` 1 and `rsp_hit` 0. It causes no memory request and changes no cache state.
- R5: On a miss with a clean or invalid victim, `busy` rises in the next cycle. The block issues a read (`mem_we` 0) at line address `{req_ptag, set}`. In the cycle after `mem_ack`, it presents `rsp_valid` 1, `rsp_hit` 0 and the addressed word, and `busy` is low again.
- R6: On a miss whose victim is valid and modified, a write (`mem_we` 1) of the victim line to `{victim tag, set}` comes before the line read. Word k of a line sits at bits 32k+31:32k of `mem_wline` and `mem_rline`.
- R7: A store that hits changes only the cache and marks the line modified. Any number of stores to a resident line cause exactly one line write, at eviction, and that write carries the latest data.
- R8: The victim is way 0 if it is invalid, else way 1 if it is invalid, else the way of that set that was used less recently. Both hits and fills count as uses.
- R9: A store that misses fetches the line, merges the store data into the addressed word, and leaves the line marked modified.
- R10: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wline` unchanged until the cycle in which `mem_ack` is sampled high.
- R11: For a store, `rsp_rdata` returns the store data. A later load of that word returns it too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Load strobe, one cycle, only while `busy` is low |
| req_wr | input | 1 | Store strobe, one cycle, only while `busy` is low |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| req_ptag | input | 18 | Physical page tag from the translation buffer |
| req_tlb_hit | input | 1 | Translation valid for this access |
| rsp_valid | output | 1 | Access completed this cycle |
| rsp_hit | output | 1 | Completed access hit in the cache |
| rsp_rdata | output | 32 | Load data, or the store data for a store |
| busy | output | 1 | Miss handling in progress |
| mem_req | output | 1 | Next-level request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 24 | Line address {physical tag, set} |
| mem_wline | output | 128 | Line being written back |
| mem_ack | input | 1 | Next level accepts the request or returns the line |
| mem_rline | input | 128 | Fetched line, valid with `mem_ack` |

## Verification
The hardest situation to reach from the ports is the eviction of a modified line that was chosen by recency, not because it was invalid. Getting there requires filling both ways of one set, storing into one of them, and then touching the other one so that the modified line becomes the less recently used. The stimulus builds this with a directed sequence on one set, using virtual addresses that differ in their upper bits. It then runs a long random run confined to three sets and four physical tags, so that modified-victim evictions happen often. A behavioural model of the ways, the recency bits and the backing memory predicts every response and every line transfer.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2
    } vc_state_e;
endpackage

// File: rtl/vipt_way_store.sv
module vipt_way_store #(
    parameter int SETS   = 64,
    parameter int TAG_W  = 18,
    parameter int LINE_W = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] rd_set,
    output logic                    rd_valid,
    output logic                    rd_dirty,
    output logic [TAG_W-1:0]        rd_tag,
    output logic [LINE_W-1:0]       rd_line,
    input  logic                    wr_en,
    input  logic [$clog2(SETS)-1:0] wr_set,
    input  logic [TAG_W-1:0]        wr_tag,
    input  logic [LINE_W-1:0]       wr_line,
    input  logic                    wr_dirty
);
    logic [SETS-1:0]   valid_d, valid_q;
    logic [SETS-1:0]   dirty_d, dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (wr_en) begin
            valid_d[wr_set] = 1'b1;
            dirty_d[wr_set] = wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    // payload needs no reset: it is never used while its valid flag is low
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            line_q[wr_set] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];
    assign rd_tag   = tag_q[rd_set];
    assign rd_line  = line_q[rd_set];
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
    parameter int SETS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] rd_set,
    output logic                    rd_old_way,
    input  logic                    upd_en,
    input  logic [$clog2(SETS)-1:0] upd_set,
    input  logic                    upd_used_way
);
    // one bit per set: the way that was used less recently
    logic [SETS-1:0] old_d, old_q;

    always_comb begin
        old_d = old_q;
        if (upd_en) old_d[upd_set] = ~upd_used_way;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) old_q <= '0;
        else        old_q <= old_d;
    end

    assign rd_old_way = old_q[rd_set];
endmodule

// File: rtl/vipt_victim.sv
module vipt_victim (
    input  logic valid0,
    input  logic valid1,
    input  logic old_way,
    output logic victim
);
    always_comb begin
        if (!valid0)      victim = 1'b0;
        else if (!valid1) victim = 1'b1;
        else              victim = old_way;
    end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PTAG_W = 18,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int SETS   = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_rd,
    input  logic                                req_wr,
    input  logic [VA_W-1:0]                     req_vaddr,
    input  logic [DATA_W-1:0]                   req_wdata,
    input  logic [PTAG_W-1:0]                   req_ptag,
    input  logic                                req_tlb_hit,
    output logic                                rsp_valid,
    output logic                                rsp_hit,
    output logic [DATA_W-1:0]                   rsp_rdata,
    output logic                                busy,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [PTAG_W+$clog2(SETS)-1:0]      mem_addr,
    output logic [DATA_W*WORDS-1:0]             mem_wline,
    input  logic                                mem_ack,
    input  logic [DATA_W*WORDS-1:0]             mem_rline
);
    localparam int WAYS   = 2;
    localparam int BYTES  = DATA_W / 8;
    localparam int BSEL_W = $clog2(BYTES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = BSEL_W + WSEL_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int LINE_W = DATA_W * WORDS;

    typedef struct packed {
        vc_state_e          st;
        logic               is_wr;
        logic [WSEL_W-1:0]  word;
        logic [DATA_W-1:0]  wdata;
        logic [IDX_W-1:0]   set;
        logic [PTAG_W-1:0]  ptag;
        logic               vic;
        logic               rsp_valid;
        logic               rsp_hit;
        logic [DATA_W-1:0]  rdata;
    } ctl_t;

    ctl_t q, d;

    // set and word come from untranslated bits only
    logic [IDX_W-1:0]  req_set;
    logic [WSEL_W-1:0] req_word;
    assign req_set  = req_vaddr[OFF_W +: IDX_W];
    assign req_word = req_vaddr[BSEL_W +: WSEL_W];

    logic unused_va;
    assign unused_va = ^{req_vaddr[VA_W-1:OFF_W+IDX_W], req_vaddr[BSEL_W-1:0]};

    logic [IDX_W-1:0]  rd_set;
    logic              way_valid [WAYS];
    logic              way_dirty [WAYS];
    logic [PTAG_W-1:0] way_tag   [WAYS];
    logic [LINE_W-1:0] way_line  [WAYS];

    logic [WAYS-1:0]   wr_way_en;
    logic [IDX_W-1:0]  wr_set;
    logic [PTAG_W-1:0] wr_tag;
    logic [LINE_W-1:0] wr_line;
    logic              wr_dirty;

    logic              old_way, victim;
    logic              lru_upd, lru_way;
    logic [IDX_W-1:0]  lru_set;

    logic [WAYS-1:0]   hit_vec;
    logic              hit_way;
    logic [LINE_W-1:0] line_tmp;

    assign rd_set = (q.st == ST_IDLE) ? req_set : q.set;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        vipt_way_store #(
            .SETS   (SETS),
            .TAG_W  (PTAG_W),
            .LINE_W (LINE_W)
        ) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_set   (rd_set),
            .rd_valid (way_valid[w]),
            .rd_dirty (way_dirty[w]),
            .rd_tag   (way_tag[w]),
            .rd_line  (way_line[w]),
            .wr_en    (wr_way_en[w]),
            .wr_set   (wr_set),
            .wr_tag   (wr_tag),
            .wr_line  (wr_line),
            .wr_dirty (wr_dirty)
        );
    end

    vipt_lru #(.SETS(SETS)) u_lru (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_set       (rd_set),
        .rd_old_way   (old_way),
        .upd_en       (lru_upd),
        .upd_set      (lru_set),
        .upd_used_way (lru_way)
    );

    vipt_victim u_victim (
        .valid0  (way_valid[0]),
        .valid1  (way_valid[1]),
        .old_way (old_way),
        .victim  (victim)
    );

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = req_tlb_hit && way_valid[w] && (way_tag[w] == req_ptag);
        end
        hit_way = hit_vec[1];
    end

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.rsp_hit   = 1'b0;
        wr_way_en   = '0;
        wr_set      = rd_set;
        wr_tag      = req_ptag;
        wr_line     = way_line[0];
        wr_dirty    = 1'b0;
        lru_upd     = 1'b0;
        lru_set     = rd_set;
        lru_way     = 1'b0;
        line_tmp    = way_line[0];

        unique case (q.st)
            ST_IDLE: begin
                if (req_rd || req_wr) begin
                    if (!req_tlb_hit) begin
                        d.rsp_valid = 1'b1;
                    end else if (|hit_vec) begin
                        line_tmp = way_line[hit_way];
                        if (req_wr) begin
                            line_tmp[int'(req_word)*DATA_W +: DATA_W] = req_wdata;
                            wr_way_en[hit_way] = 1'b1;
                            wr_tag   = way_tag[hit_way];
                            wr_line  = line_tmp;
                            wr_dirty = 1'b1;
                        end
                        lru_upd     = 1'b1;
                        lru_way     = hit_way;
                        d.rsp_valid = 1'b1;
                        d.rsp_hit   = 1'b1;
                        d.rdata     = line_tmp[int'(req_word)*DATA_W +: DATA_W];
                    end else begin
                        d.is_wr = req_wr;
                        d.word  = req_word;
                        d.wdata = req_wdata;
                        d.set   = req_set;
                        d.ptag  = req_ptag;
                        d.vic   = victim;
                        d.st    = (way_valid[victim] && way_dirty[victim]) ? ST_WB : ST_FILL;
                    end
                end
            end
            ST_WB: begin
                if (mem_ack) d.st = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack) begin
                    line_tmp = mem_rline;
                    if (q.is_wr) line_tmp[int'(q.word)*DATA_W +: DATA_W] = q.wdata;
                    wr_way_en[q.vic] = 1'b1;
                    wr_set      = q.set;
                    wr_tag      = q.ptag;
                    wr_line     = line_tmp;
                    wr_dirty    = q.is_wr;
                    lru_upd     = 1'b1;
                    lru_set     = q.set;
                    lru_way     = q.vic;
                    d.rsp_valid = 1'b1;
                    d.rdata     = line_tmp[int'(q.word)*DATA_W +: DATA_W];
                    d.st        = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_hit   = q.rsp_hit;
    assign rsp_rdata = q.rdata;
    assign busy      = (q.st != ST_IDLE);
    assign mem_req   = (q.st != ST_IDLE);
    assign mem_we    = (q.st == ST_WB);
    assign mem_addr  = (q.st == ST_WB) ? {way_tag[q.vic], q.set} : {q.ptag, q.set};
    assign mem_wline = way_line[q.vic];
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
    parameter int PTAG_W = 18,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int SETS   = 64
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_rd,
    input logic                           req_wr,
    input logic                           req_tlb_hit,
    input logic                           rsp_valid,
    input logic                           rsp_hit,
    input logic                           busy,
    input logic                           mem_req,
    input logic                           mem_we,
    input logic                           mem_ack,
    input logic [PTAG_W+$clog2(SETS)-1:0] mem_addr,
    input logic [DATA_W*WORDS-1:0]        mem_wline
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req && !rsp_valid));

    p_hit_no_traffic_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (!mem_req && !busy));

    p_tlb_miss_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (req_rd || req_wr) && !req_tlb_hit) |=> (rsp_valid && !rsp_hit && !busy));

    p_refill_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rsp_valid && !rsp_hit));

    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wline)));
endmodule

bind vipt_cache vipt_cache_chk #(
    .PTAG_W (PTAG_W),
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .SETS   (SETS)
) u_chk (.*);

// File: tb/vipt_cache_tb.sv
`timescale 1ns/1ps
module vipt_cache_tb_top;
    localparam int PTAG_W = 18;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int SETS   = 64;
    localparam int LINE_W = DATA_W * WORDS;
    localparam int MA_W   = PTAG_W + 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_rd = 1'b0, req_wr = 1'b0, req_tlb_hit = 1'b0;
    logic [31:0]       req_vaddr = '0, req_wdata = '0;
    logic [PTAG_W-1:0] req_ptag = '0;
    logic              rsp_valid, rsp_hit, busy, mem_req, mem_we;
    logic [DATA_W-1:0] rsp_rdata;
    logic [MA_W-1:0]   mem_addr;
    logic [LINE_W-1:0] mem_wline;
    logic              mem_ack = 1'b0;
    logic [LINE_W-1:0] mem_rline = '0;

    vipt_cache dut_i (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string what, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // ---------------- backing memory ----------------
    logic [LINE_W-1:0] bmem [int];

    function automatic logic [LINE_W-1:0] mem_get(input int a);
        logic [LINE_W-1:0] l;
        if (bmem.exists(a)) return bmem[a];
        for (int i = 0; i < WORDS; i++) l[i*DATA_W +: DATA_W] = 32'(a * 37 + i * 1001) ^ 32'h5a00_0000;
        return l;
    endfunction

    typedef struct {
        bit                we;
        int                addr;
        logic [LINE_W-1:0] data;
    } txn_t;
    txn_t txq[$];

    int              mcnt = 0;
    logic [MA_W-1:0] hold_addr;
    logic            hold_we;
    logic [LINE_W-1:0] hold_line;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            mcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            mcnt = 0;
        end else if (mem_req) begin
            mcnt++;
            if (mcnt == 1) begin
                hold_addr = mem_addr; hold_we = mem_we; hold_line = mem_wline;
            end else if (mcnt == 2) begin
                chk(hold_addr == mem_addr && hold_we == mem_we && (!mem_we || hold_line == mem_wline),
                    "R10 request held stable", LINE_W'(mem_addr), LINE_W'(hold_addr));
                if (mem_we) begin
                    txq.push_back('{1'b1, int'(mem_addr), mem_wline});
                    bmem[int'(mem_addr)] = mem_wline;
                end else begin
                    txq.push_back('{1'b0, int'(mem_addr), '0});
                    mem_rline = mem_get(int'(mem_addr));
                end
                mem_ack = 1'b1;
            end
        end
    end

    // ---------------- reference model ----------------
    int                m_tag  [SETS][2];
    bit                m_val  [SETS][2];
    bit                m_dty  [SETS][2];
    logic [LINE_W-1:0] m_line [SETS][2];
    bit                m_old  [SETS];

    function automatic logic [31:0] va_of(input int hi, input int set, input int word);
        return {hi[19:0], set[5:0], word[1:0], 2'b00};
    endfunction

    task automatic access(input bit wr, input logic [31:0] va, input int ptag, input bit tlb,
                          input logic [31:0] wd, input string tag);
        int  s = int'(va[9:4]);
        int  wi = int'(va[3:2]);
        bit  ehit = 0;
        int  hw = 0;
        int  v;
        bit  miss;
        logic [31:0] erd = '0;
        txn_t exq[$];
        int  c;

        if (tlb) begin
            for (int w = 0; w < 2; w++)
                if (m_val[s][w] && m_tag[s][w] == ptag) begin ehit = 1; hw = w; end
        end
        miss = tlb && !ehit;
        if (ehit) begin
            if (wr) begin m_line[s][hw][wi*32 +: 32] = wd; m_dty[s][hw] = 1; end
            erd = m_line[s][hw][wi*32 +: 32];
            m_old[s] = (hw == 0);
        end else if (miss) begin
            v = !m_val[s][0] ? 0 : (!m_val[s][1] ? 1 : int'(m_old[s]));
            if (m_val[s][v] && m_dty[s][v])
                exq.push_back('{1'b1, (m_tag[s][v] << 6) | s, m_line[s][v]});
            exq.push_back('{1'b0, (ptag << 6) | s, '0});
            m_line[s][v] = mem_get((ptag << 6) | s);
            if (wr) m_line[s][v][wi*32 +: 32] = wd;
            m_tag[s][v] = ptag; m_val[s][v] = 1; m_dty[s][v] = wr; m_old[s] = (v == 0);
            erd = m_line[s][v][wi*32 +: 32];
        end

        @(negedge clk);
        txq.delete();
        req_rd = !wr; req_wr = wr; req_vaddr = va; req_ptag = PTAG_W'(ptag);
        req_tlb_hit = tlb; req_wdata = wd;
        c = 0;
        forever begin
            @(negedge clk);
            req_rd = 1'b0; req_wr = 1'b0;
            c++;
            if (rsp_valid || c > 40) break;
            chk(busy == miss, {tag, " busy while waiting"}, LINE_W'(busy), LINE_W'(miss));
        end
        chk(rsp_valid, {tag, " response arrives"}, LINE_W'(rsp_valid), 1);
        if (!miss) chk(c == 1, {tag, " response one cycle after strobe"}, LINE_W'(c), 1);
        chk(!busy, {tag, " busy low at response"}, LINE_W'(busy), 0);
        chk(rsp_hit == ehit, {tag, " hit flag"}, LINE_W'(rsp_hit), LINE_W'(ehit));
        if (tlb) chk(rsp_rdata == erd, {tag, " read data"}, LINE_W'(rsp_rdata), LINE_W'(erd));
        chk(txq.size() == exq.size(), {tag, " memory transfer count"},
            LINE_W'(txq.size()), LINE_W'(exq.size()));
        for (int i = 0; i < exq.size() && i < txq.size(); i++) begin
            chk(txq[i].we == exq[i].we && txq[i].addr == exq[i].addr,
                {tag, " transfer kind/address"}, LINE_W'({txq[i].we, txq[i].addr}),
                LINE_W'({exq[i].we, exq[i].addr}));
            if (exq[i].we)
                chk(txq[i].data == exq[i].data, {tag, " write-back line"}, txq[i].data, exq[i].data);
        end
    endtask

    localparam int PA = 'h0ABC, PB = 'h1234, PC = 'h2222, PD = 'h3333, PE = 'h0777,
                   PF = 'h0888, PG = 'h0999;

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !rsp_valid && !mem_req, "R1 outputs quiet in reset",
            LINE_W'({busy, rsp_valid, mem_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rsp_valid && !mem_req, "R1 outputs quiet after reset",
            LINE_W'({busy, rsp_valid, mem_req}), 0);

        access(0, va_of('h11111, 5, 1), PA, 1, 0, "R1 R5 first access misses");
        access(0, va_of('h22222, 5, 2), PA, 1, 0, "R2 alias upper bits hit");
        access(0, va_of('h11111, 5, 2), PA, 0, 0, "R4 translation miss");
        access(0, va_of('h33333, 5, 3), PA, 1, 0, "R3 R4 hit after translation miss");
        access(0, va_of('h11111, 5, 0), PB, 1, 0, "R8 second way fills");
        access(0, va_of('h11111, 5, 0), PA, 1, 0, "R3 hit way 0");
        access(0, va_of('h11111, 5, 0), PC, 1, 0, "R8 evict less recent");
        access(0, va_of('h11111, 5, 1), PA, 1, 0, "R8 kept recent line");
        access(0, va_of('h11111, 5, 1), PB, 1, 0, "R8 refetch evicts other");
        access(1, va_of('h11111, 5, 0), PA, 1, 32'hDEAD_0001, "R7 R11 store hit 1");
        access(1, va_of('h44444, 5, 0), PA, 1, 32'hDEAD_0002, "R7 R11 store hit 2");
        access(1, va_of('h11111, 5, 0), PA, 1, 32'hDEAD_0003, "R7 R11 store hit 3");
        access(0, va_of('h11111, 5, 0), PA, 1, 0, "R11 load after store");
        access(0, va_of('h11111, 5, 2), PC, 1, 0, "R8 evict clean way");
        access(0, va_of('h11111, 5, 2), PD, 1, 0, "R6 R7 dirty victim written once");
        access(1, va_of('h00001, 9, 3), PE, 1, 32'hBEEF_0009, "R9 store miss");
        access(0, va_of('h00001, 9, 1), PE, 1, 0, "R9 fetched word kept");
        access(0, va_of('h00001, 9, 3), PB, 1, 0, "R3 tag mismatch misses");
        access(0, va_of('h00001, 9, 0), PF, 1, 0, "R6 R9 merged line written back");
        access(0, va_of('h00001, 9, 0), PG, 1, 0, "R8 set 9 third tag");

        for (int n = 0; n < 400; n++) begin
            int sets[3] = '{3, 7, 63};
            int s = sets[$urandom_range(2)];
            int pt = 'h100 + int'($urandom_range(3));
            bit wr = ($urandom_range(9) < 4);
            bit tl = ($urandom_range(9) != 0);
            access(wr, va_of(int'($urandom), s, int'($urandom_range(3))), pt, tl, $urandom,
                   "R3 R6 R7 R8 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule